// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block decides, cycle by cycle, when floating-point instructions may move through a machine that issues them in order and lets them complete out of order. Four functional units are tracked. An integer unit takes 1 cycle, an adder takes 4, a multiplier takes 7 and a divider takes 20. Each unit holds one instruction at a time. The block keeps a status record for every unit, and a table that names, for each architectural register, the unit that will next write it. The arithmetic datapath and the register file are outside the block; execution is modelled as a countdown of the unit's fixed latency.

Hazard checks are split across three points in an instruction's life:

- **Issue.** An instruction waits if its unit is occupied or if its destination already has a pending writer.
- **Operand read.** An instruction waits until neither source has a pending producer.
- **Write-back.** A result waits while an older, not-yet-read instruction still needs the old contents of its destination.

The front end presents one decoded instruction at a time and holds it while `issue_stall` is high. The datapath uses the per-unit read and write-back grants to move operands and results.

Top module: `scoreboard_ctl`

## Requirements
- R1: After reset no read grant, no write-back grant and no issue stall is asserted while no instruction is presented.
- R2: An instruction whose unit is occupied stalls. It issues on the second clock edge after the cycle in which that unit's write-back grant is high.
- R3: An instruction whose destination has a pending writer stalls (WAW). It issues on the second clock edge after that writer's write-back grant cycle.
- R4: An issued instruction whose sources have no pending producer gets its read grant in the cycle right after the issuing edge, for exactly one cycle.
- R5: An instruction with a pending producer for a source gets its read grant in the cycle after that producer's write-back grant cycle (RAW).
- R6: Without a WAR conflict, a unit's write-back grant comes L+1 cycles after its read grant. L is 1 for integer, 4 for add, 7 for multiply and 20 for divide.
- R7: A write-back grant is withheld while an older instruction that has not read its operands has a ready source naming the same register. It is granted in the cycle after that instruction's read grant.
- R8: A consumer that issues on the same edge at which its producer writes back treats that source as ready. It reads in the cycle after issue.
- R9: Issue is in order, at most one per cycle. While `issue_stall` is high `issue_fire` stays low and the instruction is held. Independent instructions on free units issue on consecutive edges.
- R10: The `instr_class` encoding is 0 integer, 1 add, 2 multiply, 3 divide. Grant bit i of each grant vector belongs to class i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_class | input | 2 | Unit class: 0 int, 1 add, 2 mul, 3 div |
| instr_dst | input | REG_W | Destination register |
| instr_src1 | input | REG_W | First source register |
| instr_src2 | input | REG_W | Second source register |
| issue_stall | output | 1 | Presented instruction cannot issue this cycle |
| issue_fire | output | 1 | Presented instruction issues at the next edge |
| rd_grant | output | 4 | Per-unit operand read grant |
| wb_grant | output | 4 | Per-unit result write-back grant |

## Verification
The hardest case to reach is a write-back held back by WAR. It needs a finished short instruction whose destination is still an unread, ready source of an older instruction. That older instruction must itself be stuck behind a long RAW wait. The stimulus issues a divide, then an add that needs the divide's result and also reads a second register, then an integer operation that overwrites that second register. The integer result must then sit through the whole divide latency. A second delicate case is a consumer issued on exactly the edge its producer writes back. The bench idles a counted number of cycles so that the two coincide.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int NUM_UNITS = 4;
  localparam int TAG_W = $clog2(NUM_UNITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OPS = 2'd1,
    ST_EXEC     = 2'd2,
    ST_WAIT_WB  = 2'd3
  } stage_e;

  // latency of unit u (class index) from the four top-level parameters
  function automatic int pick_latency(input int u, input int li, input int la,
                                      input int lm, input int ld);
    case (u)
      0:       return li;
      1:       return la;
      2:       return lm;
      default: return ld;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // tag of the unit in class slot u; tag 0 means "no producer"
  function automatic logic [TAG_W-1:0] unit_tag(input int u);
    return TAG_W'(u + 1);
  endfunction

  // true when producer tag q belongs to a unit writing back this cycle
  function automatic logic tag_done(input logic [TAG_W-1:0] q,
                                    input logic [NUM_UNITS-1:0] wb_mask);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (wb_mask[i] && (q == unit_tag(i))) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/sbc_regstat.sv
module sbc_regstat
  import sbc_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                set_en,
  input  logic [REG_W-1:0]                    set_reg,
  input  logic [TAG_W-1:0]                    set_tag,
  input  logic [NUM_UNITS-1:0]                clr_mask,
  input  logic [NUM_UNITS-1:0][REG_W-1:0]     clr_reg,
  input  logic [REG_W-1:0]                    look_dst,
  input  logic [REG_W-1:0]                    look_s1,
  input  logic [REG_W-1:0]                    look_s2,
  output logic [TAG_W-1:0]                    own_dst,
  output logic [TAG_W-1:0]                    own_s1,
  output logic [TAG_W-1:0]                    own_s2
);
  logic [TAG_W-1:0] owner [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic clr_hit;
    always_comb begin
      clr_hit = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++)
        if (clr_mask[u] && (clr_reg[u] == REG_W'(r))) clr_hit = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                  owner[r] <= '0;
      else if (set_en && (set_reg == REG_W'(r)))   owner[r] <= set_tag;
      else if (clr_hit)                            owner[r] <= '0;
    end
  end

  assign own_dst = owner[look_dst];
  assign own_s1  = owner[look_s1];
  assign own_s2  = owner[look_s2];

  // a new writer is only ever recorded over an empty entry (WAW guard)
  p_single_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (owner[set_reg] == '0));

  // a write-back always clears an entry that this unit owns
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_clr_chk
    p_clear_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[u] |-> (owner[clr_reg[u]] == unit_tag(u)));
  end
endmodule

// File: rtl/sbc_unit_slot.sv
module sbc_unit_slot
  import sbc_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LAT = 4,
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_hit,
  input  logic [REG_W-1:0]     iss_dst,
  input  logic [REG_W-1:0]     iss_src1,
  input  logic [REG_W-1:0]     iss_src2,
  input  logic [TAG_W-1:0]     iss_q1,
  input  logic [TAG_W-1:0]     iss_q2,
  input  logic [NUM_UNITS-1:0] wb_mask,
  input  logic                 war_block,
  output logic                 busy,
  output logic                 rd_grant,
  output logic                 wb_grant,
  output logic [REG_W-1:0]     ent_fi,
  output logic [REG_W-1:0]     ent_fj,
  output logic [REG_W-1:0]     ent_fk,
  output logic                 ent_rj,
  output logic                 ent_rk
);
  stage_e            state;
  logic [TAG_W-1:0]  qj, qk;
  logic [CNT_W-1:0]  cnt;
  logic              init_rj, init_rk;
  logic              bcast_j, bcast_k;

  // a source is ready at issue if nobody owns it or its owner writes back now
  assign init_rj = (iss_q1 == '0) || tag_done(iss_q1, wb_mask);
  assign init_rk = (iss_q2 == '0) || tag_done(iss_q2, wb_mask);
  assign bcast_j = !ent_rj && tag_done(qj, wb_mask);
  assign bcast_k = !ent_rk && tag_done(qk, wb_mask);

  assign busy     = (state != ST_IDLE);
  assign rd_grant = (state == ST_WAIT_OPS) && ent_rj && ent_rk;
  assign wb_grant = (state == ST_WAIT_WB) && !war_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ent_fi <= '0;
      ent_fj <= '0;
      ent_fk <= '0;
      qj     <= '0;
      qk     <= '0;
      ent_rj <= 1'b0;
      ent_rk <= 1'b0;
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (issue_hit) begin
            ent_fi <= iss_dst;
            ent_fj <= iss_src1;
            ent_fk <= iss_src2;
            qj     <= init_rj ? '0 : iss_q1;
            qk     <= init_rk ? '0 : iss_q2;
            ent_rj <= init_rj;
            ent_rk <= init_rk;
            state  <= ST_WAIT_OPS;
          end
        end
        ST_WAIT_OPS: begin
          if (rd_grant) begin
            ent_rj <= 1'b0;
            ent_rk <= 1'b0;
            cnt    <= CNT_W'(LAT - 1);
            state  <= ST_EXEC;
          end else begin
            if (bcast_j) begin ent_rj <= 1'b1; qj <= '0; end
            if (bcast_k) begin ent_rk <= 1'b1; qk <= '0; end
          end
        end
        ST_EXEC: begin
          if (cnt == '0) state <= ST_WAIT_WB;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: begin
          if (wb_grant) state <= ST_IDLE;
        end
      endcase
    end
  end

  p_issue_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hit |-> (state == ST_IDLE));

  p_read_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> (state == ST_EXEC) && !rd_grant);

  p_exec_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT_WB) && ($past(state) == ST_EXEC)) |-> ($past(cnt) == '0));

  p_wb_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |=> (state == ST_IDLE));
endmodule

// File: rtl/sbc_war_check.sv
module sbc_war_check
  import sbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_UNITS-1:0][REG_W-1:0] fi,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] fj,
  input  logic [NUM_UNITS-1:0][REG_W-1:0] fk,
  input  logic [NUM_UNITS-1:0]            rj,
  input  logic [NUM_UNITS-1:0]            rk,
  output logic [NUM_UNITS-1:0]            war_block
);
  // does a waiting reader still need the old value of register d
  function automatic logic needs_old(input logic [REG_W-1:0] d,
                                     input logic [REG_W-1:0] sj, input logic okj,
                                     input logic [REG_W-1:0] sk, input logic okk);
    return (okj && (sj == d)) || (okk && (sk == d));
  endfunction

  for (genvar f = 0; f < NUM_UNITS; f++) begin : g_writer
    always_comb begin
      war_block[f] = 1'b0;
      for (int g = 0; g < NUM_UNITS; g++)
        if (g != f && needs_old(fi[f], fj[g], rj[g], fk[g], rk[g]))
          war_block[f] = 1'b1;
    end
  end
endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl
  import sbc_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W = $clog2(NUM_REGS),
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [1:0]           instr_class,
  input  logic [REG_W-1:0]     instr_dst,
  input  logic [REG_W-1:0]     instr_src1,
  input  logic [REG_W-1:0]     instr_src2,
  output logic                 issue_stall,
  output logic                 issue_fire,
  output logic [NUM_UNITS-1:0] rd_grant,
  output logic [NUM_UNITS-1:0] wb_grant
);
  localparam int MAX_LAT = max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
  localparam int CNT_W = $clog2(MAX_LAT + 1);

  logic [NUM_UNITS-1:0]            slot_busy, slot_rj, slot_rk, war_blk, hit;
  logic [NUM_UNITS-1:0][REG_W-1:0] slot_fi, slot_fj, slot_fk;
  logic [TAG_W-1:0]                own_dst, own_s1, own_s2;
  logic                            unit_taken, dst_pending;

  // issue-stage checks: structural and WAW
  assign unit_taken  = slot_busy[instr_class];
  assign dst_pending = (own_dst != '0);
  assign issue_stall = instr_valid && (unit_taken || dst_pending);
  assign issue_fire  = instr_valid && !issue_stall;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LU = pick_latency(u, LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);

    assign hit[u] = issue_fire && (instr_class == 2'(u));

    sbc_unit_slot #(.REG_W(REG_W), .LAT(LU), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_hit (hit[u]),
      .iss_dst   (instr_dst),
      .iss_src1  (instr_src1),
      .iss_src2  (instr_src2),
      .iss_q1    (own_s1),
      .iss_q2    (own_s2),
      .wb_mask   (wb_grant),
      .war_block (war_blk[u]),
      .busy      (slot_busy[u]),
      .rd_grant  (rd_grant[u]),
      .wb_grant  (wb_grant[u]),
      .ent_fi    (slot_fi[u]),
      .ent_fj    (slot_fj[u]),
      .ent_fk    (slot_fk[u]),
      .ent_rj    (slot_rj[u]),
      .ent_rk    (slot_rk[u])
    );
  end

  sbc_regstat #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (issue_fire),
    .set_reg  (instr_dst),
    .set_tag  (TAG_W'(instr_class) + TAG_W'(1)),
    .clr_mask (wb_grant),
    .clr_reg  (slot_fi),
    .look_dst (instr_dst),
    .look_s1  (instr_src1),
    .look_s2  (instr_src2),
    .own_dst  (own_dst),
    .own_s1   (own_s1),
    .own_s2   (own_s2)
  );

  sbc_war_check #(.REG_W(REG_W)) u_war (
    .fi        (slot_fi),
    .fj        (slot_fj),
    .fk        (slot_fk),
    .rj        (slot_rj),
    .rk        (slot_rk),
    .war_block (war_blk)
  );

  // an issued instruction occupies its unit from the next cycle on
  p_issue_occupies_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> slot_busy[$past(instr_class)]);

  // no result lands in a register that a reader granted in the same cycle reads
  for (genvar f = 0; f < NUM_UNITS; f++) begin : g_war_f
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_war_g
      if (f != g) begin : g_pair
        p_war_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (wb_grant[f] && rd_grant[g]) |->
            ((slot_fj[g] != slot_fi[f]) && (slot_fk[g] != slot_fi[f])));
      end
    end
  end
endmodule

// File: tb/scoreboard_ctl_test.sv
`timescale 1ns/100ps
module scoreboard_ctl_test;
  localparam int L_INT = 1, L_ADD = 4, L_MUL = 7, L_DIV = 20;
  localparam int C_INT = 0, C_ADD = 1, C_MUL = 2, C_DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [1:0] instr_class = '0;
  logic [4:0] instr_dst = '0, instr_src1 = '0, instr_src2 = '0;
  logic       issue_stall, issue_fire;
  logic [3:0] rd_grant, wb_grant;

  scoreboard_ctl uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_class(instr_class),
    .instr_dst(instr_dst), .instr_src1(instr_src1), .instr_src2(instr_src2),
    .issue_stall(issue_stall), .issue_fire(issue_fire),
    .rd_grant(rd_grant), .wb_grant(wb_grant));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_total = 0, n_fail = 0;
  bit mon_on = 1'b0;

  typedef struct { int kind; int unit; int at; string req; } exp_t;
  exp_t exp_q [$];

  function automatic string kname(input int k);
    return (k == 0) ? "read" : "writeback";
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_total++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int unit, input int at, input string req);
    exp_t e;
    e.kind = kind; e.unit = unit; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic match_ev(input int kind, input int unit, input int at);
    bit found = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (!found && exp_q[i].kind == kind && exp_q[i].unit == unit && exp_q[i].at == at) begin
        found = 1'b1;
        n_total++;
        exp_q.delete(i);
        break;
      end
    end
    if (!found) begin
      n_total++;
      n_fail++;
      $display("FAIL R10: unexpected %s grant unit %0d at cycle %0d, actual 1 expected 0",
               kname(kind), unit, at);
    end
  endtask

  // monitor: scoreboard comparison of every grant against the expected queue
  always @(negedge clk) begin
    #2;
    if (mon_on)
      for (int u = 0; u < 4; u++) begin
        if (rd_grant[u]) match_ev(0, u, cyc);
        if (wb_grant[u]) match_ev(1, u, cyc);
      end
  end

  // driver: present an instruction, hold it while stalled; at = issuing edge
  task automatic issue(input int c, input int d, input int s1, input int s2,
                       output int at, output int stalls);
    stalls = 0;
    instr_valid = 1'b1;
    instr_class = 2'(c);
    instr_dst = 5'(d); instr_src1 = 5'(s1); instr_src2 = 5'(s2);
    #1;
    while (issue_stall) begin
      if (stalls == 0) chk("R9 fire low while stalled", int'(issue_fire), 0);
      stalls++;
      @(negedge clk); #1;
    end
    at = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    #(5.0 * 20000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int i1, i2, i3, i4, st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 rd_grant", int'(rd_grant), 0);
    chk("R1 wb_grant", int'(wb_grant), 0);
    chk("R1 issue_stall", int'(issue_stall), 0);
    mon_on = 1'b1;
    @(negedge clk);

    // four independent instructions, one per class (R4, R6, R9, R10)
    issue(C_INT, 1, 20, 21, i1, st);
    #1; chk("R10 int class read bit", int'(rd_grant), 1);
    expect_ev(0, C_INT, i1, "R4"); expect_ev(1, C_INT, i1 + L_INT + 1, "R6");
    issue(C_ADD, 2, 20, 21, i2, st);
    expect_ev(0, C_ADD, i2, "R4"); expect_ev(1, C_ADD, i2 + L_ADD + 1, "R6");
    issue(C_MUL, 3, 20, 21, i3, st);
    expect_ev(0, C_MUL, i3, "R4"); expect_ev(1, C_MUL, i3 + L_MUL + 1, "R6");
    issue(C_DIV, 4, 20, 21, i4, st);
    expect_ev(0, C_DIV, i4, "R4"); expect_ev(1, C_DIV, i4 + L_DIV + 1, "R6");
    chk("R9 back-to-back add", i2, i1 + 1);
    chk("R9 back-to-back mul", i3, i2 + 1);
    chk("R9 back-to-back div", i4, i3 + 1);
    idle(30);

    // structural hazard on the adder (R2)
    issue(C_ADD, 5, 20, 21, i1, st);
    expect_ev(0, C_ADD, i1, "R4"); expect_ev(1, C_ADD, i1 + L_ADD + 1, "R6");
    issue(C_ADD, 6, 20, 21, i2, st);
    chk("R2 stalled", int'(st > 0), 1);
    chk("R2 issue edge", i2, i1 + L_ADD + 1 + 2);
    expect_ev(0, C_ADD, i2, "R2"); expect_ev(1, C_ADD, i2 + L_ADD + 1, "R2");
    idle(15);

    // WAW on F7 (R3)
    issue(C_DIV, 7, 20, 21, i1, st);
    expect_ev(0, C_DIV, i1, "R4"); expect_ev(1, C_DIV, i1 + L_DIV + 1, "R6");
    issue(C_INT, 7, 20, 21, i2, st);
    chk("R3 issue edge", i2, i1 + L_DIV + 1 + 2);
    expect_ev(0, C_INT, i2, "R3"); expect_ev(1, C_INT, i2 + L_INT + 1, "R3");
    idle(10);

    // RAW: add reads the multiplier result (R5)
    issue(C_MUL, 8, 20, 21, i1, st);
    expect_ev(0, C_MUL, i1, "R4"); expect_ev(1, C_MUL, i1 + L_MUL + 1, "R6");
    issue(C_ADD, 9, 8, 20, i2, st);
    chk("R5 no issue stall", i2, i1 + 1);
    expect_ev(0, C_ADD, i1 + L_MUL + 2, "R5");
    expect_ev(1, C_ADD, i1 + L_MUL + 2 + L_ADD + 1, "R5");
    idle(20);

    // WAR: int result to F14 held until the add has read F14 (R7)
    issue(C_DIV, 12, 20, 21, i1, st);
    expect_ev(0, C_DIV, i1, "R4"); expect_ev(1, C_DIV, i1 + L_DIV + 1, "R6");
    issue(C_ADD, 13, 12, 14, i2, st);
    issue(C_INT, 14, 20, 21, i3, st);
    chk("R7 int issue edge", i3, i1 + 2);
    expect_ev(0, C_ADD, i1 + L_DIV + 2, "R5");
    expect_ev(1, C_ADD, i1 + L_DIV + 2 + L_ADD + 1, "R6");
    expect_ev(0, C_INT, i3, "R4");
    expect_ev(1, C_INT, i1 + L_DIV + 3, "R7");
    idle(35);

    // same-edge write-back and issue (R8)
    issue(C_INT, 15, 20, 21, i1, st);
    expect_ev(0, C_INT, i1, "R4"); expect_ev(1, C_INT, i1 + L_INT + 1, "R6");
    idle(2);
    issue(C_ADD, 16, 15, 20, i2, st);
    chk("R8 issue edge", i2, i1 + 3);
    expect_ev(0, C_ADD, i2, "R8"); expect_ev(1, C_ADD, i2 + L_ADD + 1, "R8");
    idle(20);

    for (int i = 0; i < exp_q.size(); i++) begin
      n_total++; n_fail++;
      $display("FAIL %s: %s grant unit %0d actual none expected at cycle %0d",
               exp_q[i].req, kname(exp_q[i].kind), exp_q[i].unit, exp_q[i].at);
    end
    report();
    $finish;
  end
endmodule